// File: doc/BRIEF.md
# Four-Channel Down-Counting Timer Bank

This peripheral holds a bank of general-purpose down-counters behind a plain register bus. Each channel loads from its own reload register when software turns it on. It then counts down by one per clock while both a bank-wide run bit and its own run bit are set. When it reaches zero it takes the reload value again on the following cycle, adds one to an overflow tally and raises a sticky event bit. The event bits, qualified by per-channel mask bits, are ORed onto a single interrupt line.

A channel's count is not read live. Reading the overflow tally also copies the live count into a holding register, and the count address then returns that copy. Software therefore reads the overflow tally first and the count second, and gets a pair taken at one clock edge. With a reload of all ones, the inverse of the held count is a free-running elapsed-cycle figure.

The bus is a simple register port and not a stream. A read or write takes effect at the clock edge where its strobe is high. There is no back-pressure and no wait state, and read data is registered: it is valid in the cycle after `bus_re`, and it holds until the next read.

Top module: `timer_bank`

## Requirements
- R1: After reset every run bit, mask bit, event bit, count, holding register and overflow tally is zero, every reload register holds 0xFFFFFFFF, and `irq_o` is low.
- R2: Offset 0x10 reads the `REVISION` parameter, and writes to it have no effect.
- R3: A channel's count changes only while the bank run bit (offset 0x00, bit 0) and its own run bit (channel offset +0x00, bit 0) are both set; otherwise it holds.
- R4: A write to the channel control register that sets bit 0 while the bit is clear loads the count from the reload register (channel offset +0x04).
- R5: While running, the count drops by one per cycle. A count of zero is replaced by the reload value on the next cycle, and in that same cycle the overflow tally increments and event bit 0 (channel offset +0x10) is set.
- R6: A read of the overflow tally (channel offset +0x0C) returns the tally and copies the live count into the holding register. A read of channel offset +0x08 returns that held value and not the live count.
- R7: An event bit stays set until a write of 1 to bit 0 of channel offset +0x14 clears it. When a wrap and a clear fall in the same cycle, the bit stays set.
- R8: `irq_o` is high exactly when some channel has both its event bit and its mask bit (channel offset +0x18, bit 0) set.
- R9: Channel n occupies offsets 0x20 + 0x20·n; channels count, wrap and are read independently.
- R10: Reads of unmapped offsets (including offsets not word-aligned and channels beyond `NUM_TIMERS`) return zero. Read data appears the cycle after `bus_re` and is otherwise held.
- R11: With a reload of 0xFFFFFFFF, the bitwise inverse of the held count equals the number of running cycles since the count was loaded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | ADDR_W | Byte address of the access |
| bus_wdata | input | DATA_W | Write data |
| bus_we | input | 1 | Write strobe, acts at the clock edge |
| bus_re | input | 1 | Read strobe, acts at the clock edge |
| bus_rdata | output | DATA_W | Registered read data, valid the cycle after `bus_re` |
| irq_o | output | 1 | OR of masked channel events |

## Verification
The bench builds the block with its defaults: four channels, 32-bit data, an 8-bit address and a fixed revision word. Every channel address window is therefore reachable, and offsets past the last channel can be shown to decode as empty. Programming small reload values such as 3 brings the wrap into reach within a few cycles. That lets the bench line up a wrap and a clear on the same edge, follow the overflow tally across two wraps, and read a count frozen after a stop. Using the full-range reset reload on a separate channel covers the free-running elapsed-count reading.

// File: rtl/timer_bank_pkg.sv
`timescale 1ns/1ps
package timer_bank_pkg;

  // Register slot inside one channel window, from address bits [4:2]
  typedef enum logic [2:0] {
    SLOT_CTRL   = 3'd0,
    SLOT_RELOAD = 3'd1,
    SLOT_HOLD   = 3'd2,
    SLOT_WRAPS  = 3'd3,
    SLOT_EVENT  = 3'd4,
    SLOT_ACK    = 3'd5,
    SLOT_MASK   = 3'd6,
    SLOT_NONE   = 3'd7
  } slot_e;

  // Slots inside the bank-wide window (window 0)
  localparam logic [2:0] BANK_SLOT_RUN = 3'd0;
  localparam logic [2:0] BANK_SLOT_REV = 3'd4;

  localparam int WINDOW_BITS = 5;  // 0x20 bytes per window

endpackage

// File: rtl/timer_bank_decode.sv
`timescale 1ns/1ps
module timer_bank_decode
  import timer_bank_pkg::*;
#(
  parameter int ADDR_W     = 8,
  parameter int NUM_TIMERS = 4
) (
  input  logic [ADDR_W-1:0]     addr,
  output logic                  hit_run,
  output logic                  hit_rev,
  output logic [NUM_TIMERS-1:0] chan_sel,
  output slot_e                 slot
);
  localparam int WIN_W = ADDR_W - WINDOW_BITS;

  logic             aligned;
  logic [WIN_W-1:0] window;
  logic [2:0]       slot_raw;

  assign aligned  = (addr[1:0] == 2'b00);
  assign window   = addr[ADDR_W-1:WINDOW_BITS];
  assign slot_raw = addr[4:2];
  assign slot     = slot_e'(slot_raw);

  assign hit_run = aligned && (window == '0) && (slot_raw == BANK_SLOT_RUN);
  assign hit_rev = aligned && (window == '0) && (slot_raw == BANK_SLOT_REV);

  for (genvar g = 0; g < NUM_TIMERS; g++) begin : g_sel
    assign chan_sel[g] = aligned && (window == WIN_W'(g + 1)) &&
                         (slot_raw != SLOT_NONE);
  end

endmodule

// File: rtl/timer_bank_channel.sv
`timescale 1ns/1ps
module timer_bank_channel
  import timer_bank_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bank_run,
  input  logic             sel,
  input  logic             we,
  input  logic             re,
  input  slot_e            slot,
  input  logic [CNT_W-1:0] wdata,
  output logic [CNT_W-1:0] rdata,
  output logic             event_o,
  output logic             irq_req
);
  logic             run_bit;
  logic             mask_bit;
  logic             event_bit;
  logic [CNT_W-1:0] reload_q;
  logic [CNT_W-1:0] live_q;
  logic [CNT_W-1:0] hold_q;
  logic [CNT_W-1:0] wraps_q;

  logic wr, rd, start, running, wrap, ack;

  assign wr      = sel && we;
  assign rd      = sel && re;
  assign start   = wr && (slot == SLOT_CTRL) && wdata[0] && !run_bit;
  assign running = bank_run && run_bit;
  assign wrap    = running && (live_q == '0);
  assign ack     = wr && (slot == SLOT_ACK) && wdata[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_bit   <= 1'b0;
      mask_bit  <= 1'b0;
      event_bit <= 1'b0;
      reload_q  <= '1;
      live_q    <= '0;
      hold_q    <= '0;
      wraps_q   <= '0;
    end else begin
      if (wr && slot == SLOT_CTRL)   run_bit  <= wdata[0];
      if (wr && slot == SLOT_RELOAD) reload_q <= wdata;
      if (wr && slot == SLOT_MASK)   mask_bit <= wdata[0];

      if (start)        live_q <= reload_q;
      else if (wrap)    live_q <= reload_q;
      else if (running) live_q <= live_q - CNT_W'(1);

      if (wrap) wraps_q <= wraps_q + CNT_W'(1);

      if (wrap)     event_bit <= 1'b1;
      else if (ack) event_bit <= 1'b0;

      if (rd && slot == SLOT_WRAPS) hold_q <= live_q;
    end
  end

  always_comb begin
    unique case (slot)
      SLOT_CTRL:   rdata = CNT_W'(run_bit);
      SLOT_RELOAD: rdata = reload_q;
      SLOT_HOLD:   rdata = hold_q;
      SLOT_WRAPS:  rdata = wraps_q;
      SLOT_EVENT:  rdata = CNT_W'(event_bit);
      SLOT_MASK:   rdata = CNT_W'(mask_bit);
      default:     rdata = '0;
    endcase
  end

  assign event_o = event_bit;
  assign irq_req = event_bit && mask_bit;

  // R5
  count_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (running && live_q != '0) |=> (live_q == $past(live_q) - CNT_W'(1)));

  // R3
  frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!running && !start) |=> $stable(live_q));

  // R5
  wrap_effect_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wrap |=> (event_bit && wraps_q == $past(wraps_q) + CNT_W'(1)
              && live_q == $past(reload_q)));

  // R7
  event_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (event_bit && !ack) |=> event_bit);

  // R4
  start_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (live_q == $past(reload_q) && run_bit));

endmodule

// File: rtl/timer_bank.sv
`timescale 1ns/1ps
module timer_bank
  import timer_bank_pkg::*;
#(
  parameter int          NUM_TIMERS = 4,
  parameter int          DATA_W     = 32,
  parameter int          ADDR_W     = 8,
  parameter logic [31:0] REVISION   = 32'h0001_0203
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  input  logic              bus_we,
  input  logic              bus_re,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              irq_o
);
  logic                  hit_run, hit_rev;
  logic [NUM_TIMERS-1:0] chan_sel;
  slot_e                 slot;
  logic                  bank_run;
  logic [NUM_TIMERS-1:0] irq_vec;
  logic [NUM_TIMERS-1:0] event_vec;
  logic [DATA_W-1:0]     chan_rdata [NUM_TIMERS];
  logic [DATA_W-1:0]     rdata_d;

  timer_bank_decode #(
    .ADDR_W     (ADDR_W),
    .NUM_TIMERS (NUM_TIMERS)
  ) decode_i (
    .addr     (bus_addr),
    .hit_run  (hit_run),
    .hit_rev  (hit_rev),
    .chan_sel (chan_sel),
    .slot     (slot)
  );

  for (genvar g = 0; g < NUM_TIMERS; g++) begin : g_chan
    timer_bank_channel #(.CNT_W(DATA_W)) chan_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .bank_run (bank_run),
      .sel      (chan_sel[g]),
      .we       (bus_we),
      .re       (bus_re),
      .slot     (slot),
      .wdata    (bus_wdata),
      .rdata    (chan_rdata[g]),
      .event_o  (event_vec[g]),
      .irq_req  (irq_vec[g])
    );
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                  bank_run <= 1'b0;
    else if (bus_we && hit_run)  bank_run <= bus_wdata[0];
  end

  always_comb begin
    rdata_d = '0;
    if (hit_run) rdata_d = DATA_W'(bank_run);
    if (hit_rev) rdata_d = DATA_W'(REVISION);
    for (int i = 0; i < NUM_TIMERS; i++) begin
      if (chan_sel[i]) rdata_d = chan_rdata[i];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      bus_rdata <= '0;
    else if (bus_re) bus_rdata <= rdata_d;
  end

  assign irq_o = |irq_vec;

  // R10
  rdata_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_re |=> $stable(bus_rdata));

  // R8
  irq_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> (event_vec != '0));

  // R2
  rev_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_re && hit_rev) |=> (bus_rdata == DATA_W'(REVISION)));

  // R10
  unmapped_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_re && !hit_run && !hit_rev && chan_sel == '0) |=> (bus_rdata == '0));

endmodule

// File: tb/timer_bank_tb_top.sv
`timescale 1ns/1ps
module timer_bank_tb_top;
  localparam int          AW  = 8;
  localparam int          DW  = 32;
  localparam logic [31:0] REV = 32'h0001_0203;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [AW-1:0] bus_addr = '0;
  logic [DW-1:0] bus_wdata = '0;
  logic          bus_we = 1'b0;
  logic          bus_re = 1'b0;
  logic [DW-1:0] bus_rdata;
  logic          irq_o;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  always #10 clk = ~clk;

  timer_bank #(
    .NUM_TIMERS (4),
    .DATA_W     (DW),
    .ADDR_W     (AW),
    .REVISION   (REV)
  ) dut_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_we    (bus_we),
    .bus_re    (bus_re),
    .bus_rdata (bus_rdata),
    .irq_o     (irq_o)
  );

  task automatic chk(input string req, input logic [DW-1:0] act,
                     input logic [DW-1:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  // Every bus task starts and ends at a falling edge and spans one rising edge
  task automatic wr(input logic [AW-1:0] a, input logic [DW-1:0] d);
    bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(input logic [AW-1:0] a, output logic [DW-1:0] d);
    bus_addr = a; bus_re = 1'b1;
    @(negedge clk);
    bus_re = 1'b0;
    d = bus_rdata;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic t_reset();
    logic [DW-1:0] v;
    chk("R1 irq", DW'(irq_o), '0);
    rd(8'h00, v); chk("R1 bank run", v, '0);
    rd(8'h24, v); chk("R1 reload", v, 32'hFFFF_FFFF);
    rd(8'h2C, v); chk("R1 wraps", v, '0);
    rd(8'h28, v); chk("R1 held count", v, '0);
    rd(8'h30, v); chk("R1 event", v, '0);
    rd(8'h38, v); chk("R1 mask", v, '0);
  endtask

  task automatic t_revision();
    logic [DW-1:0] v;
    rd(8'h10, v); chk("R2 revision", v, REV);
    wr(8'h10, 32'hDEAD_BEEF);
    rd(8'h10, v); chk("R2 revision after write", v, REV);
  endtask

  task automatic t_unmapped();
    logic [DW-1:0] v;
    rd(8'h04, v); chk("R10 unmapped 0x04", v, '0);
    rd(8'h3C, v); chk("R10 unmapped slot 7", v, '0);
    rd(8'hA0, v); chk("R10 beyond channels", v, '0);
    rd(8'h25, v); chk("R10 unaligned", v, '0);
  endtask

  task automatic t_gate();
    logic [DW-1:0] v;
    wr(8'h44, 32'h100);
    wr(8'h40, 32'h1);           // channel 1 on, bank off
    idle(5);
    rd(8'h4C, v); chk("R3 no wraps while bank off", v, '0);
    rd(8'h48, v); chk("R4 load, R3 frozen", v, 32'h100);
    wr(8'h00, 32'h1);           // edge G: bank run takes effect after it
    idle(3);                    // G+1..G+3: 0xFF, 0xFE, 0xFD
    rd(8'h4C, v); chk("R6 wraps read", v, '0);
    rd(8'h48, v); chk("R5 R6 held count", v, 32'hFD);
  endtask

  task automatic t_wrap();
    logic [DW-1:0] v;
    wr(8'h24, 32'h3);
    wr(8'h20, 32'h1);           // A: 3
    idle(5);                    // 2,1,0,wrap->3,2
    rd(8'h2C, v); chk("R5 wrap tally", v, 32'h1);
    rd(8'h28, v); chk("R6 held not live", v, 32'h2);
    rd(8'h30, v); chk("R5 event set", v, 32'h1);
    chk("R8 masked irq low", DW'(irq_o), '0);
    wr(8'h38, 32'h1);
    chk("R8 irq on mask", DW'(irq_o), 32'h1);
    wr(8'h20, 32'h0);           // stop; count frozen at 1
    rd(8'h30, v); chk("R7 sticky event", v, 32'h1);
    wr(8'h34, 32'h1);
    rd(8'h30, v); chk("R7 cleared", v, '0);
    chk("R8 irq after clear", DW'(irq_o), '0);
  endtask

  task automatic t_set_wins();
    logic [DW-1:0] v;
    wr(8'h64, 32'h3);
    wr(8'h78, 32'h1);
    wr(8'h60, 32'h1);           // B: 3
    idle(3);                    // 2,1,0
    wr(8'h74, 32'h1);           // clear on the wrap edge
    rd(8'h70, v); chk("R7 wrap beats clear", v, 32'h1);
    chk("R8 irq channel 2", DW'(irq_o), 32'h1);
    wr(8'h60, 32'h0);
    wr(8'h74, 32'h1);
    chk("R8 irq low again", DW'(irq_o), '0);
  endtask

  task automatic t_free_run();
    logic [DW-1:0] v;
    wr(8'h80, 32'h1);           // F: all ones from reset reload
    idle(9);
    rd(8'h8C, v); chk("R11 no wrap", v, '0);
    rd(8'h88, v); chk("R11 elapsed", ~v, 32'd9);
    rd(8'h2C, v); chk("R9 channel 0 tally untouched", v, 32'h2);
    rd(8'h28, v); chk("R9 channel 0 frozen count", v, 32'h1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_revision();
    t_unmapped();
    t_gate();
    t_wrap();
    t_set_wins();
    t_free_run();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures",
               n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    #(20 * 200000);
    if (!done) begin
      done = 1'b1;
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures",
               n_checks, n_fail);
      $finish;
    end
  end

endmodule